// File: doc/BRIEF.md
# Synthesizer Counter Programming Interface

This block is the control-word front end of a frequency synthesizer. It produces the settings for the main divider M (9 bits), the swallow counter A (4 bits), the reference divider R (6 bits), an active-low prescaler enable and an 8-bit enhancement byte. The dividers, the phase detector and all analog parts sit outside it.

Settings reach the block in one of three ways. The serial port shifts bits into a 20-bit primary word or an 8-bit enhancement word. The parallel port takes byte writes, and each write strobe places its byte into fixed fields of the primary word. In direct mode, M, A and the prescaler enable come straight from pins. A hop strobe copies the primary word into a secondary word. A bank-select input chooses which of the two words feeds the counters, so a host can stage the next frequency while the current one stays in use.

Every strobe, the serial clock, the data and the mode pins pass through a two-flop synchronizer into the system clock. A register then detects the rising edge, so each strobe edge acts exactly once.

Top module: `synth_prog_if`

## Requirements
- R1: After reset the primary, secondary and enhancement words are zero, so with direct mode off all counter outputs and enhByte read zero.
- R2: In serial mode (modeDirect=0, modeSerial=1) with enhWr low, each rising serClk edge shifts serData into the primary word, MSB first. The primary word layout is bit 19 prescaler enable, bits 18:10 M, bits 9:4 R, bits 3:0 A.
- R3: In serial mode with enhWr high, each rising serClk edge shifts serData MSB first into the enhancement word and leaves the primary word unchanged.
- R4: In parallel mode (modeDirect=0, modeSerial=0) a rising m1Wr edge loads parData[7] into the prescaler enable and parData[6:0] into M[6:0].
- R5: In parallel mode a rising m2Wr edge loads parData[3:2] into R[5:4] and parData[1:0] into M[8:7].
- R6: In parallel mode a rising aWr edge loads parData[7:4] into R[3:0] and parData[3:0] into A[3:0].
- R7: In parallel mode a rising enhWr edge loads parData[7:0] into the enhancement word.
- R8: In any mode a rising hopWr edge copies the whole primary word into the secondary word. The secondary word changes at no other time.
- R9: With direct mode off, bankSel=1 drives the counters from the primary word and bankSel=0 drives them from the secondary word.
- R10: In direct mode (modeDirect=1), mCnt, aCnt and preEnN follow dirM, dirA and dirPreEnN. rCnt still comes from the word chosen by bankSel. Serial and parallel loads are ignored in this mode.
- R11: Parallel write strobes have no effect in serial mode, and serClk edges have no effect in parallel mode.
- R12: A strobe or serClk held high for many cycles acts only once, on its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeDirect | input | 1 | 1 selects direct pin mode |
| modeSerial | input | 1 | With modeDirect=0: 1 serial, 0 parallel |
| serClk | input | 1 | Serial shift clock (acts on rising edge) |
| serData | input | 1 | Serial data bit |
| enhWr | input | 1 | Serial: level routes shifts to enhancement; parallel: rising-edge byte write |
| parData | input | 8 | Parallel data byte |
| m1Wr | input | 1 | Parallel write: prescaler enable and M[6:0] |
| m2Wr | input | 1 | Parallel write: R[5:4] and M[8:7] |
| aWr | input | 1 | Parallel write: R[3:0] and A[3:0] |
| hopWr | input | 1 | Copies primary into secondary on rising edge |
| bankSel | input | 1 | 1 primary, 0 secondary as counter source |
| dirM | input | 9 | Direct-mode M value |
| dirA | input | 4 | Direct-mode A value |
| dirPreEnN | input | 1 | Direct-mode prescaler enable, active low |
| mCnt | output | 9 | M counter setting |
| aCnt | output | 4 | A counter setting |
| rCnt | output | 6 | R counter setting |
| preEnN | output | 1 | Prescaler enable, active low (1 bypasses prescaler) |
| enhByte | output | 8 | Enhancement byte |

## Verification
The bench targets the scattered parallel fields. If the bit slices of m2Wr or aWr were swapped, R and M would come back with the wrong nibble or pair of bits. It also holds serClk and the strobes high for many cycles, which catches a design that acts on levels instead of edges and so shifts or reloads repeatedly. Writes are issued in the wrong mode and in direct mode, and the bench then reads the words back in a mode where they are visible. A design that leaks loads across modes, or that updates the secondary word without a hop, shows up as a mismatch there. Random mixes of serial words, byte writes, hops and bank toggles are compared against a bench model of both words.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int M_W    = 9;
  localparam int A_W    = 4;
  localparam int R_W    = 6;
  localparam int ENH_W  = 8;
  localparam int BUS_W  = 8;
  localparam int PRI_W  = 1 + M_W + R_W + A_W;
  localparam int A_LSB  = 0;
  localparam int R_LSB  = A_LSB + A_W;
  localparam int M_LSB  = R_LSB + R_W;
  localparam int PE_BIT = PRI_W - 1;

  typedef struct packed {
    logic shiftPri;
    logic shiftEnh;
    logic ldM1;
    logic ldM2;
    logic ldA;
    logic ldEnh;
    logic hop;
  } strobe_t;

  typedef enum logic [1:0] {MODE_PAR = 2'd0, MODE_SER = 2'd1, MODE_DIR = 2'd2} mode_t;
endpackage

// File: rtl/synth_prog_sync.sv
module synth_prog_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/synth_prog_ctrl.sv
module synth_prog_ctrl
  import synth_prog_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    modeDirS,
  input  logic    modeSerS,
  input  logic    serClkS,
  input  logic    enhWrS,
  input  logic    m1S,
  input  logic    m2S,
  input  logic    aS,
  input  logic    hopS,
  output strobe_t strb,
  output mode_t   mode
);
  localparam int NEDGE = 6;

  logic [NEDGE-1:0] cur, prev, rise;

  assign cur = {serClkS, enhWrS, m1S, m2S, aS, hopS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prev <= '0;
    else       prev <= cur;
  end

  assign rise = cur & ~prev;

  always_comb begin
    if (modeDirS)      mode = MODE_DIR;
    else if (modeSerS) mode = MODE_SER;
    else               mode = MODE_PAR;
  end

  always_comb begin
    strb          = '0;
    strb.shiftPri = (mode == MODE_SER) && rise[5] && !enhWrS;
    strb.shiftEnh = (mode == MODE_SER) && rise[5] &&  enhWrS;
    strb.ldEnh    = (mode == MODE_PAR) && rise[4];
    strb.ldM1     = (mode == MODE_PAR) && rise[3];
    strb.ldM2     = (mode == MODE_PAR) && rise[2];
    strb.ldA      = (mode == MODE_PAR) && rise[1];
    strb.hop      = rise[0];
  end
endmodule

// File: rtl/synth_prog_dp.sv
module synth_prog_dp
  import synth_prog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic             serBit,
  input  logic [BUS_W-1:0] parByte,
  input  logic             isDirect,
  input  logic             bankSel,
  input  logic [M_W-1:0]   dirM,
  input  logic [A_W-1:0]   dirA,
  input  logic             dirPreEnN,
  output logic [PRI_W-1:0] priReg,
  output logic [PRI_W-1:0] secReg,
  output logic [ENH_W-1:0] enhReg,
  output logic [M_W-1:0]   mCnt,
  output logic [A_W-1:0]   aCnt,
  output logic [R_W-1:0]   rCnt,
  output logic             preEnN
);
  logic [PRI_W-1:0] srcWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      priReg <= '0;
    end else begin
      if (strb.shiftPri) priReg <= {priReg[PRI_W-2:0], serBit};
      if (strb.ldM1) begin
        priReg[PE_BIT]      <= parByte[7];
        priReg[M_LSB +: 7]  <= parByte[6:0];
      end
      if (strb.ldM2) begin
        priReg[R_LSB+4 +: 2] <= parByte[3:2];
        priReg[M_LSB+7 +: 2] <= parByte[1:0];
      end
      if (strb.ldA) begin
        priReg[R_LSB +: 4] <= parByte[7:4];
        priReg[A_LSB +: 4] <= parByte[3:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         secReg <= '0;
    else if (strb.hop) secReg <= priReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              enhReg <= '0;
    else if (strb.shiftEnh) enhReg <= {enhReg[ENH_W-2:0], serBit};
    else if (strb.ldEnh)    enhReg <= parByte;
  end

  assign srcWord = bankSel ? priReg : secReg;

  always_comb begin
    rCnt = srcWord[R_LSB +: R_W];
    if (isDirect) begin
      mCnt   = dirM;
      aCnt   = dirA;
      preEnN = dirPreEnN;
    end else begin
      mCnt   = srcWord[M_LSB +: M_W];
      aCnt   = srcWord[A_LSB +: A_W];
      preEnN = srcWord[PE_BIT];
    end
  end
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeDirect,
  input  logic             modeSerial,
  input  logic             serClk,
  input  logic             serData,
  input  logic             enhWr,
  input  logic [BUS_W-1:0] parData,
  input  logic             m1Wr,
  input  logic             m2Wr,
  input  logic             aWr,
  input  logic             hopWr,
  input  logic             bankSel,
  input  logic [M_W-1:0]   dirM,
  input  logic [A_W-1:0]   dirA,
  input  logic             dirPreEnN,
  output logic [M_W-1:0]   mCnt,
  output logic [A_W-1:0]   aCnt,
  output logic [R_W-1:0]   rCnt,
  output logic             preEnN,
  output logic [ENH_W-1:0] enhByte
);
  localparam int NLEVEL = 9;
  localparam int SYNC_W = NLEVEL + BUS_W;

  logic [SYNC_W-1:0] rawIn, syncOut;
  logic              modeDirS, modeSerS, serClkS, serBitS, enhWrS;
  logic              m1S, m2S, aS, hopS;
  logic [BUS_W-1:0]  parByteS;
  strobe_t           strb;
  mode_t             mode;
  logic              isDirect;
  logic [PRI_W-1:0]  priQ, secQ;
  logic [ENH_W-1:0]  enhQ;

  assign rawIn = {modeDirect, modeSerial, serClk, serData, enhWr,
                  m1Wr, m2Wr, aWr, hopWr, parData};

  synth_prog_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN), .d(rawIn), .q(syncOut)
  );

  assign {modeDirS, modeSerS, serClkS, serBitS, enhWrS,
          m1S, m2S, aS, hopS, parByteS} = syncOut;

  synth_prog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeDirS(modeDirS), .modeSerS(modeSerS),
    .serClkS(serClkS), .enhWrS(enhWrS), .m1S(m1S), .m2S(m2S), .aS(aS),
    .hopS(hopS), .strb(strb), .mode(mode)
  );

  assign isDirect = (mode == MODE_DIR);

  synth_prog_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .serBit(serBitS), .parByte(parByteS),
    .isDirect(isDirect), .bankSel(bankSel), .dirM(dirM), .dirA(dirA),
    .dirPreEnN(dirPreEnN), .priReg(priQ), .secReg(secQ), .enhReg(enhQ),
    .mCnt(mCnt), .aCnt(aCnt), .rCnt(rCnt), .preEnN(preEnN)
  );

  assign enhByte = enhQ;
endmodule

// File: rtl/synth_prog_chk.sv
module synth_prog_chk
  import synth_prog_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input strobe_t          strb,
  input logic             serBit,
  input logic [PRI_W-1:0] priReg,
  input logic [PRI_W-1:0] secReg,
  input logic             isDirect,
  input logic [M_W-1:0]   dirM,
  input logic [A_W-1:0]   dirA,
  input logic             dirPreEnN,
  input logic [M_W-1:0]   mCnt,
  input logic [A_W-1:0]   aCnt,
  input logic             preEnN
);
  logic anyShift, anyPar;
  assign anyShift = strb.shiftPri | strb.shiftEnh;
  assign anyPar   = strb.ldM1 | strb.ldM2 | strb.ldA | strb.ldEnh;

  AST_SHIFT_MSB_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftPri |=> priReg == {$past(priReg[PRI_W-2:0]), $past(serBit)}); // R2
  AST_ENH_SHIFT_KEEPS_PRI: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shiftEnh && !strb.hop) |=> $stable(priReg)); // R3
  AST_HOP_COPY: assert property (@(posedge clk) disable iff (!rstN)
    strb.hop |=> secReg == $past(priReg)); // R8
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.hop |=> $stable(secReg)); // R8
  AST_DIRECT_PINS: assert property (@(posedge clk) disable iff (!rstN)
    isDirect |-> (mCnt == dirM && aCnt == dirA && preEnN == dirPreEnN)); // R10
  AST_DIRECT_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    isDirect |-> !(anyShift || anyPar)); // R10
  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({anyShift, anyPar})); // R11
endmodule

bind synth_prog_if synth_prog_chk u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .serBit(serBitS), .priReg(priQ),
  .secReg(secQ), .isDirect(isDirect), .dirM(dirM), .dirA(dirA),
  .dirPreEnN(dirPreEnN), .mCnt(mCnt), .aCnt(aCnt), .preEnN(preEnN)
);

// File: tb/synth_prog_if_tb.sv
`timescale 1ns/1ps
module synth_prog_if_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic modeDirect = 0, modeSerial = 0, serClk = 0, serData = 0, enhWr = 0;
  logic [7:0] parData = '0;
  logic m1Wr = 0, m2Wr = 0, aWr = 0, hopWr = 0, bankSel = 1;
  logic [8:0] dirM = '0;
  logic [3:0] dirA = '0;
  logic dirPreEnN = 0;
  logic [8:0] mCnt;
  logic [3:0] aCnt;
  logic [5:0] rCnt;
  logic preEnN;
  logic [7:0] enhByte;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [19:0] mPri = '0, mSec = '0;
  logic [7:0]  mEnh = '0;

  always #4 clk = ~clk;

  synth_prog_if u_dut (
    .clk(clk), .rstN(rstN), .modeDirect(modeDirect), .modeSerial(modeSerial),
    .serClk(serClk), .serData(serData), .enhWr(enhWr), .parData(parData),
    .m1Wr(m1Wr), .m2Wr(m2Wr), .aWr(aWr), .hopWr(hopWr), .bankSel(bankSel),
    .dirM(dirM), .dirA(dirA), .dirPreEnN(dirPreEnN), .mCnt(mCnt), .aCnt(aCnt),
    .rCnt(rCnt), .preEnN(preEnN), .enhByte(enhByte)
  );

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    logic [19:0] src;
    waitN(4);
    src = bankSel ? mPri : mSec;
    cmp(tag, "mCnt",   int'(mCnt),   modeDirect ? int'(dirM) : int'(src[18:10]));
    cmp(tag, "aCnt",   int'(aCnt),   modeDirect ? int'(dirA) : int'(src[3:0]));
    cmp(tag, "preEnN", int'(preEnN), modeDirect ? int'(dirPreEnN) : int'(src[19]));
    cmp(tag, "rCnt",   int'(rCnt),   int'(src[9:4]));
    cmp(tag, "enhByte", int'(enhByte), int'(mEnh));
  endtask

  task automatic setMode(input logic dir, input logic ser);
    modeDirect = dir;
    modeSerial = ser;
    waitN(5);
  endtask

  function automatic bit isSer();
    return !modeDirect && modeSerial;
  endfunction
  function automatic bit isPar();
    return !modeDirect && !modeSerial;
  endfunction

  task automatic serPulse(input logic b, input logic toEnh, input int hold);
    serData = b;
    enhWr   = toEnh;
    waitN(1);
    serClk = 1;
    waitN(hold);
    serClk = 0;
    waitN(3);
    if (isSer()) begin
      if (toEnh) mEnh = {mEnh[6:0], b};
      else       mPri = {mPri[18:0], b};
    end
    enhWr = 0;
    waitN(1);
  endtask

  task automatic serWord(input logic [19:0] w, input int n, input logic toEnh);
    for (int i = n - 1; i >= 0; i--) serPulse(w[i], toEnh, 3);
  endtask

  task automatic parW(input int which, input logic [7:0] d, input int hold);
    parData = d;
    waitN(1);
    case (which)
      0: m1Wr = 1;
      1: m2Wr = 1;
      2: aWr = 1;
      default: enhWr = 1;
    endcase
    waitN(hold);
    m1Wr = 0; m2Wr = 0; aWr = 0; enhWr = 0;
    waitN(3);
    if (isPar()) begin
      case (which)
        0: begin mPri[19] = d[7]; mPri[16:10] = d[6:0]; end
        1: begin mPri[9:8] = d[3:2]; mPri[18:17] = d[1:0]; end
        2: begin mPri[7:4] = d[7:4]; mPri[3:0] = d[3:0]; end
        default: mEnh = d;
      endcase
    end
  endtask

  task automatic hop(input int hold);
    hopWr = 1;
    waitN(hold);
    hopWr = 0;
    waitN(3);
    mSec = mPri;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    waitN(3);
    rstN = 1;
    waitN(2);
    checkAll("R1 reset primary");
    bankSel = 0;
    checkAll("R1 reset secondary");
    bankSel = 1;

    // R2 serial word into primary with a known layout
    setMode(0, 1);
    serWord({1'b1, 9'h1A5, 6'h2C, 4'h9}, 20, 1'b0);
    checkAll("R2 serial primary");
    cmp("R2 layout", "mCnt", int'(mCnt), 'h1A5);
    // R3 enhancement shift leaves primary alone
    serWord(20'h000C3, 8, 1'b1);
    checkAll("R3 serial enh");
    cmp("R3 enh value", "enhByte", int'(enhByte), 'hC3);
    // R12 long serClk hold shifts one bit only
    serPulse(1'b1, 1'b0, 20);
    checkAll("R12 serClk held");
    // R11 parallel strobe ignored in serial mode
    parW(0, 8'hFF, 3);
    checkAll("R11 m1Wr in serial");

    // parallel writes
    setMode(0, 0);
    parW(0, 8'h5A, 3);  checkAll("R4 m1Wr");
    parW(1, 8'h0B, 3);  checkAll("R5 m2Wr");
    parW(2, 8'hE7, 3);  checkAll("R6 aWr");
    cmp("R6 field", "rCnt", int'(rCnt), int'({2'b10, 4'hE}));
    parW(3, 8'h3C, 3);  checkAll("R7 enh write");
    parW(2, 8'h11, 25); checkAll("R12 aWr held");
    serPulse(1'b1, 1'b0, 3);
    checkAll("R11 serClk in parallel");

    // R8 hop and R9 bank select
    hop(3);
    bankSel = 0; checkAll("R8 hop copy");
    parW(0, 8'h81, 3);
    checkAll("R8 secondary holds");
    bankSel = 1; checkAll("R9 primary selected");
    hop(30);
    bankSel = 0; checkAll("R12 hop held");

    // R10 direct mode
    dirM = 9'h13F; dirA = 4'h6; dirPreEnN = 1;
    setMode(1, 0);
    checkAll("R10 direct pins");
    parW(0, 8'h22, 3);
    serPulse(1'b1, 1'b0, 3);
    setMode(0, 0);
    bankSel = 1;
    checkAll("R10 no load in direct");

    // random mix
    for (int it = 0; it < 60; it++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: begin setMode(0, 1); serWord(20'($urandom), 20, 1'b0); end
        1: begin setMode(0, 1); serWord(20'($urandom), 8, 1'b1); end
        2: begin setMode(0, 0); parW($urandom_range(0, 3), 8'($urandom), 3); end
        3: hop(3);
        4: bankSel = ~bankSel;
        default: begin
          dirM = 9'($urandom); dirA = 4'($urandom); dirPreEnN = 1'($urandom);
          setMode(1, 0);
        end
      endcase
      checkAll("R9 random mix");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule